// File: doc/BRIEF.md
# Clear-on-Read Event Counter Bank with Shared Byte Latch

This block keeps a bank of 16-bit event counters, one per event strobe, and lets an 8-bit host read them over a narrow register bus. Each counter occupies two neighbouring byte addresses: the even offset returns bits 15:8 and the odd offset returns bits 7:0. Any read of either byte returns that byte and zeroes the whole counter in the same clock.

In that same clock, the byte the host did not ask for is stored in one latch that all counters share. The latch has its own address. The host reads it on its next access and so gets both halves of one 16-bit value, in either order, even though the counter has already been cleared.

The counters stop at 0xFFFF instead of wrapping. An event that arrives in the cycle of a clearing read is counted into the new count, so it is not lost. Read data is registered and appears one clock after the read strobe.

Top module: `roc_counter_bank`

## Requirements
- R1: After synchronous reset, every counter, the shared latch and `rd_data` are 0x00/0x0000.
- R2: Each clock in which `evt[k]` is high, and no clearing read of counter k happens, raises counter k by one.
- R3: A counter at 0xFFFF stays at 0xFFFF under further events; its high and low bytes then both read 0xFF.
- R4: Counter k sits at `BASE_ADDR+2k` (high byte, bits 15:8) and `BASE_ADDR+2k+1` (low byte, bits 7:0). `rd_data` shows the addressed byte on the clock after the cycle in which `rd_en` is high, and keeps that value until the next read.
- R5: A read of either byte of a counter sets all 16 bits of that counter to zero.
- R6: On a counter-byte read, the other byte of the same counter is copied into the shared latch at `HOLD_ADDR` (default 0x6C). The returned byte and the latched byte come from the same value, taken before the clear.
- R7: If `evt[k]` is high in the cycle of a clearing read of counter k, that counter becomes 1 and not 0.
- R8: A read of `HOLD_ADDR` returns the latch and changes neither the latch nor any counter. The latch keeps its value until the next counter-byte read.
- R9: A read of an address that maps to no counter and is not `HOLD_ADDR` returns 0x00 and changes no counter and not the latch.
- R10: An event on one counter never changes another counter. The latch always captures a byte of the addressed counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt | input | NUM_CNT | One event strobe per counter |
| rd_en | input | 1 | Read strobe, one access per high cycle |
| rd_addr | input | ADDR_W | Byte address of the read |
| rd_data | output | 8 | Registered read data |

## Verification
The two functions that can fall in one clock are a clearing read of a counter and an event on that same counter. Directed steps hold the strobe high across the read, and the random phase drives event strobes and reads independently, so the two meet often. The result is judged by a later low-byte read, which must show 0x01, together with the bytes returned and latched at the read itself, which must hold the full value from before the clear.

// File: rtl/roc_pkg.sv
package roc_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 2 * BYTE_W;

  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [CNT_W-1:0]  cnt_t;

  localparam cnt_t CNT_MAX = '1;

  function automatic byte_t hi_byte(input cnt_t v);
    return v[CNT_W-1:BYTE_W];
  endfunction

  function automatic byte_t lo_byte(input cnt_t v);
    return v[BYTE_W-1:0];
  endfunction
endpackage

// File: rtl/roc_event_counter.sv
module roc_event_counter
  import roc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic evt,
  input  logic clr,
  output cnt_t cnt
);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (clr) begin
      cnt <= evt ? cnt_t'(1) : '0;
    end else if (evt && (cnt != CNT_MAX)) begin
      cnt <= cnt + cnt_t'(1);
    end
  end

  p_count_step_r2: assert property (@(posedge clk) disable iff (rst)
    (!clr && evt && cnt != CNT_MAX) |=> (cnt == $past(cnt) + cnt_t'(1)));

  p_no_event_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!clr && !evt) |=> $stable(cnt));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    (!clr && cnt == CNT_MAX) |=> (cnt == CNT_MAX));

  p_clear_r5: assert property (@(posedge clk) disable iff (rst)
    (clr && !evt) |=> (cnt == '0));

  p_keep_event_r7: assert property (@(posedge clk) disable iff (rst)
    (clr && evt) |=> (cnt == cnt_t'(1)));

endmodule

// File: rtl/roc_addr_decode.sv
module roc_addr_decode #(
  parameter int                NUM_CNT   = 4,
  parameter int                ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h50,
  parameter logic [ADDR_W-1:0] HOLD_ADDR = 8'h6C
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [NUM_CNT-1:0] cnt_hit,
  output logic              hi_sel,
  output logic              hold_hit
);

  logic [ADDR_W-1:0] offset;

  assign offset   = rd_addr - BASE_ADDR;
  assign hi_sel   = ~offset[0];
  assign hold_hit = rd_en && (rd_addr == HOLD_ADDR);

  for (genvar k = 0; k < NUM_CNT; k++) begin : g_slot
    localparam logic [ADDR_W-1:0] HI_A = ADDR_W'(BASE_ADDR + 2 * k);
    localparam logic [ADDR_W-1:0] LO_A = ADDR_W'(BASE_ADDR + 2 * k + 1);
    assign cnt_hit[k] = rd_en && ((rd_addr == HI_A) || (rd_addr == LO_A));
  end

  p_one_target_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot0({hold_hit, cnt_hit}));

  p_idle_no_hit_r9: assert property (@(posedge clk) disable iff (rst)
    !rd_en |-> (cnt_hit == '0 && !hold_hit));

endmodule

// File: rtl/roc_read_path.sv
module roc_read_path
  import roc_pkg::*;
#(
  parameter int NUM_CNT = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rd_en,
  input  logic [NUM_CNT-1:0] cnt_hit,
  input  logic               hi_sel,
  input  logic               hold_hit,
  input  cnt_t               cnt_all [NUM_CNT],
  output byte_t              rd_data,
  output byte_t              hold_q
);

  cnt_t  snapshot;
  byte_t picked;
  byte_t other;

  always_comb begin
    snapshot = '0;
    for (int k = 0; k < NUM_CNT; k++) begin
      if (cnt_hit[k]) snapshot = snapshot | cnt_all[k];
    end
    picked = hi_sel ? hi_byte(snapshot) : lo_byte(snapshot);
    other  = hi_sel ? lo_byte(snapshot) : hi_byte(snapshot);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
      hold_q  <= '0;
    end else if (rd_en) begin
      if (|cnt_hit) begin
        rd_data <= picked;
        hold_q  <= other;
      end else if (hold_hit) begin
        rd_data <= hold_q;
      end else begin
        rd_data <= '0;
      end
    end
  end

  p_same_snapshot_r6: assert property (@(posedge clk) disable iff (rst)
    (|cnt_hit) |=> ({rd_data, hold_q} == ($past(hi_sel) ? $past(snapshot)
                                          : {$past(snapshot[7:0]), $past(snapshot[15:8])})));

  p_hold_keep_r8: assert property (@(posedge clk) disable iff (rst)
    !(|cnt_hit) |=> $stable(hold_q));

  p_hold_return_r8: assert property (@(posedge clk) disable iff (rst)
    hold_hit |=> (rd_data == $past(hold_q)));

  p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !(|cnt_hit) && !hold_hit) |=> (rd_data == '0));

  p_data_steady_r4: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));

endmodule

// File: rtl/roc_counter_bank.sv
module roc_counter_bank
  import roc_pkg::*;
#(
  parameter int                NUM_CNT   = 4,
  parameter int                ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h50,
  parameter logic [ADDR_W-1:0] HOLD_ADDR = 8'h6C
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_CNT-1:0] evt,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic [BYTE_W-1:0]  rd_data
);

  logic [NUM_CNT-1:0] cnt_hit;
  logic               hi_sel;
  logic               hold_hit;
  cnt_t               cnt_all [NUM_CNT];
  byte_t              hold_q;
  byte_t              rd_byte;

  roc_addr_decode #(
    .NUM_CNT  (NUM_CNT),
    .ADDR_W   (ADDR_W),
    .BASE_ADDR(BASE_ADDR),
    .HOLD_ADDR(HOLD_ADDR)
  ) u_decode (
    .clk     (clk),
    .rst     (rst),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .cnt_hit (cnt_hit),
    .hi_sel  (hi_sel),
    .hold_hit(hold_hit)
  );

  for (genvar k = 0; k < NUM_CNT; k++) begin : g_cnt
    roc_event_counter u_cnt (
      .clk(clk),
      .rst(rst),
      .evt(evt[k]),
      .clr(cnt_hit[k]),
      .cnt(cnt_all[k])
    );

    p_isolated_r10: assert property (@(posedge clk) disable iff (rst)
      (!evt[k] && !cnt_hit[k]) |=> $stable(cnt_all[k]));
  end

  roc_read_path #(
    .NUM_CNT(NUM_CNT)
  ) u_read (
    .clk     (clk),
    .rst     (rst),
    .rd_en   (rd_en),
    .cnt_hit (cnt_hit),
    .hi_sel  (hi_sel),
    .hold_hit(hold_hit),
    .cnt_all (cnt_all),
    .rd_data (rd_byte),
    .hold_q  (hold_q)
  );

  assign rd_data = rd_byte;

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (rd_data == '0 && hold_q == '0));

endmodule

// File: tb/test_roc_counter_bank.sv
module test_roc_counter_bank;
  localparam int         N    = 4;
  localparam logic [7:0] BASE = 8'h50;
  localparam logic [7:0] HOLD = 8'h6C;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] evt = '0;
  logic         rd_en = 1'b0;
  logic [7:0]   rd_addr = '0;
  logic [7:0]   rd_data;

  int unsigned  m_cnt [N];
  logic [7:0]   m_hold;
  int           n_cmp = 0;
  int           n_bad = 0;
  int           cyc = 0;
  bit           done = 0;

  roc_counter_bank #(.NUM_CNT(N), .ADDR_W(8), .BASE_ADDR(BASE), .HOLD_ADDR(HOLD))
    i_roc_counter_bank (.clk(clk), .rst(rst), .evt(evt), .rd_en(rd_en),
                        .rd_addr(rd_addr), .rd_data(rd_data));

  always #10 clk = ~clk;

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      done = 1;
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog: actual cycle %0d expected end before 150000", cyc);
      summary();
    end
  end

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  function automatic bit is_cnt(input logic [7:0] a);
    return (a >= BASE) && (a < BASE + 8'(2 * N));
  endfunction

  // Drives one cycle at the falling edge; expected values use the model state
  // before the rising edge, then the model advances.
  task automatic step(input logic [N-1:0] ev, input bit rd, input logic [7:0] addr,
                      input string req);
    logic [7:0] exp;
    int k;
    int unsigned v;
    bit hi;
    exp = 8'h00;
    k = -1;
    evt = ev; rd_en = rd; rd_addr = addr;
    if (rd) begin
      if (is_cnt(addr)) begin
        k  = int'(addr - BASE) / 2;
        hi = ((addr - BASE) % 2) == 0;
        v  = m_cnt[k];
        exp    = hi ? v[15:8] : v[7:0];
        m_hold = hi ? v[7:0]  : v[15:8];
      end else if (addr == HOLD) begin
        exp = m_hold;
      end
    end
    for (int j = 0; j < N; j++) begin
      if (j == k) m_cnt[j] = ev[j] ? 1 : 0;
      else if (ev[j] && m_cnt[j] < 32'hFFFF) m_cnt[j] = m_cnt[j] + 1;
    end
    @(posedge clk);
    @(negedge clk);
    evt = '0; rd_en = 1'b0;
    if (rd) check(rd_data, exp, req);
  endtask

  task automatic pulses(input int idx, input int n);
    for (int i = 0; i < n; i++) step(N'(1) << idx, 1'b0, 8'h00, "");
  endtask

  initial begin
    for (int j = 0; j < N; j++) m_cnt[j] = 0;
    m_hold = 8'h00;
    void'($urandom(32'd1977));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check(rd_data, 8'h00, "R1 rd_data after reset");
    step('0, 1'b1, HOLD, "R1 latch after reset");
    step('0, 1'b1, BASE + 8'd1, "R1 counter after reset");

    // R2 R4: low byte of counter 1 after three events, then latch and high byte
    pulses(1, 3);
    step('0, 1'b1, BASE + 8'd3, "R4 R2 low byte");
    step('0, 1'b1, HOLD, "R6 latched high byte");
    step('0, 1'b1, BASE + 8'd2, "R5 cleared high byte");

    // R6: 0x0102 read low byte first, latch gives high byte
    pulses(0, 258);
    step('0, 1'b1, BASE + 8'd1, "R6 low byte first");
    step('0, 1'b1, HOLD, "R6 latch high byte");
    step('0, 1'b1, BASE, "R5 counter zero after read");

    // R7: event in the cycle of the clearing read
    pulses(2, 5);
    step(4'b0100, 1'b1, BASE + 8'd4, "R7 read with event");
    step('0, 1'b1, HOLD, "R6 pre-clear snapshot");
    step('0, 1'b1, BASE + 8'd5, "R7 counter became one");

    // R8: latch reads leave latch and counter alone
    pulses(3, 7);
    step('0, 1'b1, BASE + 8'd6, "R8 setup high byte");
    pulses(3, 2);
    step('0, 1'b1, HOLD, "R8 latch first read");
    step('0, 1'b1, HOLD, "R8 latch second read");
    step('0, 1'b1, BASE + 8'd7, "R8 counter untouched by latch read");

    // R9: unmapped address
    pulses(1, 4);
    step('0, 1'b1, 8'h40, "R9 unmapped low");
    step('0, 1'b1, BASE + 8'(2 * N), "R9 unmapped above bank");
    step('0, 1'b1, HOLD, "R9 latch unchanged");
    step('0, 1'b1, BASE + 8'd3, "R9 counter unchanged");

    // R10: neighbour activity
    pulses(1, 6);
    pulses(3, 9);
    step('0, 1'b1, BASE + 8'd7, "R10 own counter");
    step('0, 1'b1, HOLD, "R10 latch from addressed counter");
    step('0, 1'b1, BASE + 8'd3, "R10 neighbour count");

    // R3: saturation
    pulses(0, 65540);
    step('0, 1'b1, BASE, "R3 saturated high byte");
    step('0, 1'b1, HOLD, "R3 saturated low byte");

    // Random mix: R2 R5 R6 R7 R8 R9 R10
    for (int i = 0; i < 4000; i++) begin
      logic [N-1:0] ev;
      logic [7:0]   a;
      bit           rd;
      ev = N'($urandom);
      rd = ($urandom % 3) == 0;
      case ($urandom % 4)
        0:       a = HOLD;
        1:       a = BASE - 8'd2 + 8'($urandom % (2 * N + 4));
        default: a = BASE + 8'($urandom % (2 * N));
      endcase
      step(ev, rd, a, "R6 R10 random read");
    end

    done = 1;
    summary();
  end
endmodule